// File: doc/BRIEF.md
# Operand-Holding Reorder Buffer with Rename Table

This block tracks in-flight instructions between in-order dispatch and in-order retirement. Each of its eight circular slots serves as both reorder entry and reservation station. A slot stores the opcode, the destination register, both source operands with their values, and the result with its exception flag. A value is named by the slot index of the instruction that produces it. An architectural table beside the buffer keeps, for each register, a pending flag, the producing slot index and the committed value.

A front end presents one instruction per cycle on the dispatch port and must hold it while `disp_ready` is low. Each cycle the buffer offers the oldest instruction whose operands have both arrived to an execution unit. That unit later returns the result on the completion port, tagged with the slot index. The completion is broadcast to every waiting operand. The oldest slot retires once its result is in. If it carries no exception, its value is written into the architectural table and shown on the commit port. If it carries an exception, the buffer empties, the table drops every pending mark, and the trap port presents the handler address for one cycle.

Top module: `robd_top`

## Requirements
- R1: `disp_ready` is low when all 8 slots hold instructions or when a trap is shown in the same cycle; a dispatch is accepted only when `disp_valid` and `disp_ready` are both high, and the occupancy then grows by one unless a commit happens in the same cycle.
- R2: Slots are filled in circular order starting at index 0 after reset. The tag of an instruction, seen on `iss_tag` and `cmt_tag`, is the 3-bit index of the slot it was dispatched into.
- R3: At dispatch, each source is resolved in this order. A register with no pending writer gives its architectural value. Otherwise a producer slot that has already completed gives its result. Otherwise a completion of that producer's tag in the same cycle gives the completion data. Otherwise the source waits for the producer's tag.
- R4: `iss_valid` names the oldest valid, not yet issued slot whose two sources are both present, counting age from the oldest slot. Each slot is offered exactly once.
- R5: A completion with `cmp_valid` high writes `cmp_data` into every waiting source whose tag equals `cmp_tag`, and stores the result and `cmp_exc` in slot `cmp_tag`.
- R6: Dispatching an instruction with `disp_dst_en` high makes its slot the pending producer of `disp_dst`. Later readers of that register receive this producer's value, even when its source fields name the same register.
- R7: When the oldest slot has completed without exception, `cmt_valid` is high with its tag, destination and result. The value becomes the register's architectural value, and commit tags advance by one modulo 8.
- R8: A commit clears a register's pending state only if the table still names the committing slot as producer, so an older commit never hides a newer pending writer.
- R9: When the oldest slot has completed with its exception flag set, `trap_valid` is high with `trap_pc` = 16'h0100. In the next cycle the buffer is empty, filling restarts at the trapping slot's index, and every register reads its last committed value.
- R10: After reset the buffer is empty, every register reads 0 with no pending writer, `disp_ready` is high, and `iss_valid`, `cmt_valid` and `trap_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_op | input | 2 | Opcode carried to issue |
| disp_dst_en | input | 1 | Instruction writes a register |
| disp_dst | input | 3 | Destination register |
| disp_src1 | input | 3 | First source register |
| disp_src2 | input | 3 | Second source register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| iss_valid | output | 1 | An instruction is offered to execution |
| iss_tag | output | 3 | Slot index of the offered instruction |
| iss_op | output | 2 | Opcode of the offered instruction |
| iss_a | output | 16 | First operand value |
| iss_b | output | 16 | Second operand value |
| cmp_valid | input | 1 | Completion broadcast |
| cmp_tag | input | 3 | Slot index of the completing instruction |
| cmp_data | input | 16 | Result value |
| cmp_exc | input | 1 | Result carries an exception |
| cmt_valid | output | 1 | Oldest instruction retires this cycle |
| cmt_tag | output | 3 | Slot index of the retiring instruction |
| cmt_dst_en | output | 1 | Retiring instruction writes a register |
| cmt_dst | output | 3 | Register written by the retirement |
| cmt_data | output | 16 | Value written by the retirement |
| trap_valid | output | 1 | Oldest instruction raised an exception; flush |
| trap_pc | output | 16 | Handler address |

## Verification
Checks that run every cycle cover the following. Occupancy stays within eight slots and moves by exactly one on a lone dispatch or a lone commit. No slot is offered twice in a row. Consecutive commits carry consecutive tags. A trap leaves an empty, quiet buffer in the following cycle. Some properties only show when a reference model tracks every operand and register through mixed latencies, tight register reuse, buffer-full stalls and repeated flushes. These are correct operand values under bypass and same-cycle forwarding, oldest-first selection, and the rule that an older commit does not hide a newer writer. The bench compares them on every clock.

// File: rtl/robd_pkg.sv
package robd_pkg;
    localparam int SLOTS = 8;              // power of two: pointers wrap naturally
    localparam int REGS  = 8;
    localparam int DW    = 16;
    localparam int OPW   = 2;
    localparam int TW    = $clog2(SLOTS);
    localparam int RW    = $clog2(REGS);
    localparam int CW    = $clog2(SLOTS + 1);
    localparam logic [DW-1:0] TRAP_VEC = 16'h0100;

    typedef logic [TW-1:0]  tag_t;
    typedef logic [RW-1:0]  areg_t;
    typedef logic [DW-1:0]  word_t;
    typedef logic [OPW-1:0] op_t;

    // presence / producer tag / value triple, used for sources and table entries
    typedef struct packed {
        logic  p;
        tag_t  tag;
        word_t val;
    } opnd_t;

    typedef struct packed {
        logic  valid;
        logic  issued;
        logic  done;
        logic  exc;
        op_t   op;
        logic  dst_en;
        areg_t dst;
        opnd_t s1;
        opnd_t s2;
        word_t res;
    } slot_t;

    function automatic tag_t tag_inc(tag_t t);
        return t + tag_t'(1);
    endfunction
endpackage

// File: rtl/robd_rename.sv
module robd_rename
    import robd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  areg_t rd_a,
    input  areg_t rd_b,
    output opnd_t ent_a,
    output opnd_t ent_b,
    input  logic  dw_en,
    input  areg_t dw_reg,
    input  tag_t  dw_tag,
    input  logic  cw_en,
    input  areg_t cw_reg,
    input  tag_t  cw_tag,
    input  word_t cw_val,
    input  logic  flush
);
    opnd_t ent [REGS];

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[r] <= '{p: 1'b1, tag: '0, val: '0};
            end else if (flush) begin
                ent[r].p <= 1'b1;
            end else begin
                if (cw_en && cw_reg == areg_t'(r)) begin
                    ent[r].val <= cw_val;
                    // R8: only the newest writer may clear the pending mark
                    if (ent[r].tag == cw_tag) ent[r].p <= 1'b1;
                end
                // R6: a new writer in the same cycle takes precedence
                if (dw_en && dw_reg == areg_t'(r)) begin
                    ent[r].p   <= 1'b0;
                    ent[r].tag <= dw_tag;
                end
            end
        end
    end

    assign ent_a = ent[rd_a];
    assign ent_b = ent[rd_b];
endmodule

// File: rtl/robd_srcfix.sv
module robd_srcfix
    import robd_pkg::*;
(
    input  opnd_t tbl,
    input  logic  prod_done,
    input  word_t prod_res,
    input  logic  cmp_v,
    input  tag_t  cmp_tag,
    input  word_t cmp_data,
    output opnd_t o
);
    // R3: architectural value, then finished producer, then same-cycle broadcast
    always_comb begin
        o = tbl;
        if (!tbl.p) begin
            if (prod_done) begin
                o.p   = 1'b1;
                o.val = prod_res;
            end else if (cmp_v && cmp_tag == tbl.tag) begin
                o.p   = 1'b1;
                o.val = cmp_data;
            end
        end
    end
endmodule

// File: rtl/robd_pick.sv
module robd_pick
    import robd_pkg::*;
(
    input  logic [SLOTS-1:0] req,
    input  tag_t             base,
    output logic             hit,
    output tag_t             sel
);
    // R4: scan from the oldest slot; the smallest age offset wins
    always_comb begin
        tag_t idx;
        hit = 1'b0;
        sel = base;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            idx = base + tag_t'(k);
            if (req[idx]) begin
                hit = 1'b1;
                sel = idx;
            end
        end
    end
endmodule

// File: rtl/robd_top.sv
module robd_top
    import robd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  disp_valid,
    input  logic [OPW-1:0]        disp_op,
    input  logic                  disp_dst_en,
    input  logic [RW-1:0]         disp_dst,
    input  logic [RW-1:0]         disp_src1,
    input  logic [RW-1:0]         disp_src2,
    output logic                  disp_ready,
    output logic                  iss_valid,
    output logic [TW-1:0]         iss_tag,
    output logic [OPW-1:0]        iss_op,
    output logic [DW-1:0]         iss_a,
    output logic [DW-1:0]         iss_b,
    input  logic                  cmp_valid,
    input  logic [TW-1:0]         cmp_tag,
    input  logic [DW-1:0]         cmp_data,
    input  logic                  cmp_exc,
    output logic                  cmt_valid,
    output logic [TW-1:0]         cmt_tag,
    output logic                  cmt_dst_en,
    output logic [RW-1:0]         cmt_dst,
    output logic [DW-1:0]         cmt_data,
    output logic                  trap_valid,
    output logic [DW-1:0]         trap_pc
);
    slot_t          rob [SLOTS];
    tag_t           old_q, free_q;
    logic [CW-1:0]  occ_q;

    slot_t            head;
    logic             head_fin, disp_fire;
    logic [SLOTS-1:0] rdy;
    opnd_t            tbl_a, tbl_b, src_a, src_b;
    slot_t            nslot;

    // ---- retirement view of the oldest slot (R7, R9)
    assign head       = rob[old_q];
    assign head_fin   = head.valid && head.done;
    assign cmt_valid  = head_fin && !head.exc;
    assign trap_valid = head_fin && head.exc;
    assign cmt_tag    = old_q;
    assign cmt_dst_en = head.dst_en;
    assign cmt_dst    = head.dst;
    assign cmt_data   = head.res;
    assign trap_pc    = TRAP_VEC;

    // ---- dispatch acceptance (R1)
    assign disp_ready = (occ_q != CW'(SLOTS)) && !trap_valid;
    assign disp_fire  = disp_valid && disp_ready;

    // ---- issue select (R4)
    for (genvar i = 0; i < SLOTS; i++) begin : g_rdy
        assign rdy[i] = rob[i].valid && !rob[i].issued && rob[i].s1.p && rob[i].s2.p;
    end

    robd_pick u_pick (
        .req  (rdy),
        .base (old_q),
        .hit  (iss_valid),
        .sel  (iss_tag)
    );

    assign iss_op = rob[iss_tag].op;
    assign iss_a  = rob[iss_tag].s1.val;
    assign iss_b  = rob[iss_tag].s2.val;

    // ---- rename table and source resolution (R3, R6, R8)
    robd_rename u_ren (
        .clk    (clk),
        .rst    (rst),
        .rd_a   (disp_src1),
        .rd_b   (disp_src2),
        .ent_a  (tbl_a),
        .ent_b  (tbl_b),
        .dw_en  (disp_fire && disp_dst_en),
        .dw_reg (disp_dst),
        .dw_tag (free_q),
        .cw_en  (cmt_valid && head.dst_en),
        .cw_reg (head.dst),
        .cw_tag (old_q),
        .cw_val (head.res),
        .flush  (trap_valid)
    );

    robd_srcfix u_fix_a (
        .tbl       (tbl_a),
        .prod_done (rob[tbl_a.tag].done),
        .prod_res  (rob[tbl_a.tag].res),
        .cmp_v     (cmp_valid),
        .cmp_tag   (cmp_tag),
        .cmp_data  (cmp_data),
        .o         (src_a)
    );

    robd_srcfix u_fix_b (
        .tbl       (tbl_b),
        .prod_done (rob[tbl_b.tag].done),
        .prod_res  (rob[tbl_b.tag].res),
        .cmp_v     (cmp_valid),
        .cmp_tag   (cmp_tag),
        .cmp_data  (cmp_data),
        .o         (src_b)
    );

    always_comb begin
        nslot        = '0;
        nslot.valid  = 1'b1;
        nslot.op     = disp_op;
        nslot.dst_en = disp_dst_en;
        nslot.dst    = disp_dst;
        nslot.s1     = src_a;
        nslot.s2     = src_b;
    end

    // ---- slot state
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) rob[i] <= '0;
            old_q  <= '0;
            free_q <= '0;
            occ_q  <= '0;
        end else if (trap_valid) begin
            // R9: flush everything, refill from the trapping slot
            for (int i = 0; i < SLOTS; i++) rob[i].valid <= 1'b0;
            free_q <= old_q;
            occ_q  <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (cmp_valid && rob[i].valid) begin
                    // R5: wake-up of waiting sources
                    if (!rob[i].s1.p && rob[i].s1.tag == cmp_tag) begin
                        rob[i].s1.p   <= 1'b1;
                        rob[i].s1.val <= cmp_data;
                    end
                    if (!rob[i].s2.p && rob[i].s2.tag == cmp_tag) begin
                        rob[i].s2.p   <= 1'b1;
                        rob[i].s2.val <= cmp_data;
                    end
                    if (tag_t'(i) == cmp_tag) begin
                        rob[i].done <= 1'b1;
                        rob[i].res  <= cmp_data;
                        rob[i].exc  <= cmp_exc;
                    end
                end
                if (iss_valid && tag_t'(i) == iss_tag) rob[i].issued <= 1'b1;
            end
            if (cmt_valid) begin
                rob[old_q].valid <= 1'b0;
                old_q            <= tag_inc(old_q);
            end
            if (disp_fire) begin
                rob[free_q] <= nslot;
                free_q      <= tag_inc(free_q);
            end
            occ_q <= occ_q + CW'(disp_fire) - CW'(cmt_valid);
        end
    end
endmodule

// File: rtl/robd_chk.sv
module robd_chk
    import robd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          disp_valid,
    input logic          disp_ready,
    input logic          iss_valid,
    input tag_t          iss_tag,
    input logic          cmt_valid,
    input tag_t          cmt_tag,
    input logic          trap_valid,
    input logic [CW-1:0] occ
);
    a_r1_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(SLOTS));

    a_r1_occ_grow: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_ready && !cmt_valid) |=> occ == $past(occ) + CW'(1));

    a_r7_occ_shrink: assert property (@(posedge clk) disable iff (rst)
        (!(disp_valid && disp_ready) && cmt_valid) |=> occ == $past(occ) - CW'(1));

    a_r4_issue_once: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !(iss_valid && iss_tag == $past(iss_tag)));

    a_r7_commit_order: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |=> (!cmt_valid || cmt_tag == tag_inc($past(cmt_tag))));

    a_r9_trap_empties: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> (occ == '0 && !iss_valid && !cmt_valid && !trap_valid));
endmodule

bind robd_top robd_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_ready (disp_ready),
    .iss_valid  (iss_valid),
    .iss_tag    (iss_tag),
    .cmt_valid  (cmt_valid),
    .cmt_tag    (cmt_tag),
    .trap_valid (trap_valid),
    .occ        (occ_q)
);

// File: tb/robd_top_bench.sv
module robd_top_bench;
    import robd_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    always #2.5 clk = ~clk;   // 200 MHz

    logic  disp_valid = 0, disp_dst_en = 0;
    op_t   disp_op = '0;
    areg_t disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
    logic  cmp_valid = 0, cmp_exc = 0;
    tag_t  cmp_tag = '0;
    word_t cmp_data = '0;
    logic  disp_ready, iss_valid, cmt_valid, cmt_dst_en, trap_valid;
    tag_t  iss_tag, cmt_tag;
    op_t   iss_op;
    areg_t cmt_dst;
    word_t iss_a, iss_b, cmt_data, trap_pc;

    robd_top u_robd_top (.*);

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    // ---- behavioural reference state
    bit    mv[8], mi[8], md[8], mx[8], mde[8], p1[8], p2[8];
    int    t1[8], t2[8], mdst[8], mop[8];
    word_t v1[8], v2[8], mres[8];
    int    mold, mfree, mocc;
    bit    tp[8];
    int    tt[8];
    word_t tv[8];

    typedef struct { int tag; int when; word_t data; bit exc; } job_t;
    job_t xq[$];
    int   seq = 0;

    bit e_cmt, e_trap, e_ready, e_iss;
    int e_itag;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int j = 0; j < 8; j++) begin
            mv[j] = 0; mi[j] = 0; md[j] = 0; mx[j] = 0;
            tp[j] = 1; tt[j] = 0; tv[j] = '0;
        end
        mold = 0; mfree = 0; mocc = 0;
    endtask

    task automatic predict();
        e_cmt   = mv[mold] && md[mold] && !mx[mold];
        e_trap  = mv[mold] && md[mold] && mx[mold];
        e_ready = (mocc < 8) && !e_trap;
        e_iss = 0; e_itag = 0;
        for (int k = 7; k >= 0; k--) begin
            int j = (mold + k) % 8;
            if (mv[j] && !mi[j] && p1[j] && p2[j]) begin e_iss = 1; e_itag = j; end
        end
    endtask

    task automatic compare();
        chk(disp_ready == e_ready, "R1", "disp_ready", disp_ready, e_ready);
        chk(iss_valid == e_iss, "R4", "iss_valid", iss_valid, e_iss);
        if (e_iss && iss_valid) begin
            chk(iss_tag == tag_t'(e_itag), "R2/R4", "iss_tag", iss_tag, e_itag);
            chk(iss_op == op_t'(mop[e_itag]), "R4", "iss_op", iss_op, mop[e_itag]);
            chk(iss_a == v1[e_itag], "R3/R5/R6/R8", "iss_a", iss_a, v1[e_itag]);
            chk(iss_b == v2[e_itag], "R3/R5/R6/R8", "iss_b", iss_b, v2[e_itag]);
        end
        chk(cmt_valid == e_cmt, "R7", "cmt_valid", cmt_valid, e_cmt);
        if (e_cmt && cmt_valid) begin
            chk(cmt_tag == tag_t'(mold), "R2/R7", "cmt_tag", cmt_tag, mold);
            chk(cmt_dst_en == mde[mold], "R7", "cmt_dst_en", cmt_dst_en, mde[mold]);
            if (mde[mold])
                chk(cmt_dst == areg_t'(mdst[mold]), "R7", "cmt_dst", cmt_dst, mdst[mold]);
            chk(cmt_data == mres[mold], "R7", "cmt_data", cmt_data, mres[mold]);
        end
        chk(trap_valid == e_trap, "R9", "trap_valid", trap_valid, e_trap);
        if (e_trap && trap_valid)
            chk(trap_pc == 16'h0100, "R9", "trap_pc", trap_pc, 16'h0100);
    endtask

    task automatic read_src(input int r, output bit p, output int t, output word_t v);
        p = 1; t = 0; v = '0;
        if (tp[r]) v = tv[r];
        else begin
            t = tt[r];
            if (md[t]) v = mres[t];
            else if (cmp_valid && int'(cmp_tag) == t) v = cmp_data;
            else p = 0;
        end
    endtask

    task automatic step();
        bit fire, np1, np2;
        int nt1, nt2;
        word_t nv1, nv2, r;
        if (e_trap) begin
            for (int j = 0; j < 8; j++) begin mv[j] = 0; tp[j] = 1; end
            mfree = mold; mocc = 0;
            xq.delete();
            return;
        end
        fire = disp_valid && e_ready;
        if (fire) begin
            read_src(int'(disp_src1), np1, nt1, nv1);
            read_src(int'(disp_src2), np2, nt2, nv2);
        end
        if (cmp_valid) begin
            for (int j = 0; j < 8; j++) if (mv[j]) begin
                if (!p1[j] && t1[j] == int'(cmp_tag)) begin p1[j] = 1; v1[j] = cmp_data; end
                if (!p2[j] && t2[j] == int'(cmp_tag)) begin p2[j] = 1; v2[j] = cmp_data; end
                if (j == int'(cmp_tag)) begin md[j] = 1; mres[j] = cmp_data; mx[j] = cmp_exc; end
            end
        end
        if (e_iss) begin
            job_t jb;
            mi[e_itag] = 1;
            seq++;
            case (mop[e_itag])
                0: r = v1[e_itag] + v2[e_itag] + word_t'(seq);
                1: r = v1[e_itag] - v2[e_itag];
                2: r = v1[e_itag] ^ v2[e_itag] ^ 16'h3c5a;
                default: r = v1[e_itag];
            endcase
            jb.tag = e_itag; jb.data = r; jb.exc = (mop[e_itag] == 3);
            jb.when = cyc + 1 + ($urandom % 4);
            xq.push_back(jb);
        end
        if (e_cmt) begin
            if (mde[mold]) begin
                tv[mdst[mold]] = mres[mold];
                if (tt[mdst[mold]] == mold) tp[mdst[mold]] = 1;   // R8
            end
            mv[mold] = 0; mold = (mold + 1) % 8; mocc--;
        end
        if (fire) begin
            mv[mfree] = 1; mi[mfree] = 0; md[mfree] = 0; mx[mfree] = 0;
            mop[mfree] = int'(disp_op); mde[mfree] = disp_dst_en; mdst[mfree] = int'(disp_dst);
            p1[mfree] = np1; t1[mfree] = nt1; v1[mfree] = nv1;
            p2[mfree] = np2; t2[mfree] = nt2; v2[mfree] = nv2;
            if (disp_dst_en) begin tp[int'(disp_dst)] = 0; tt[int'(disp_dst)] = mfree; end  // R6
            mfree = (mfree + 1) % 8; mocc++;
        end
    endtask

    task automatic drive(input bit hold, input int regmask, input int excdiv);
        cmp_valid = 0; cmp_exc = 0; cmp_tag = '0; cmp_data = '0;
        if (!hold) begin
            for (int q = 0; q < xq.size(); q++) begin
                if (xq[q].when <= cyc) begin
                    cmp_valid = 1; cmp_tag = tag_t'(xq[q].tag);
                    cmp_data = xq[q].data; cmp_exc = xq[q].exc;
                    xq.delete(q);
                    break;
                end
            end
        end
        disp_valid  = hold ? 1'b1 : (($urandom % 4) != 0);
        disp_op     = (($urandom % excdiv) == 0) ? op_t'(3) : op_t'($urandom % 3);
        disp_dst_en = (($urandom % 6) != 0);
        disp_dst    = areg_t'($urandom % regmask);
        disp_src1   = areg_t'($urandom % regmask);
        disp_src2   = areg_t'($urandom % regmask);
    endtask

    initial begin
        void'($urandom(11));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R10: reset state at the ports
        chk(disp_ready == 1'b1, "R10", "disp_ready", disp_ready, 1);
        chk(iss_valid == 1'b0, "R10", "iss_valid", iss_valid, 0);
        chk(cmt_valid == 1'b0, "R10", "cmt_valid", cmt_valid, 0);
        chk(trap_valid == 1'b0, "R10", "trap_valid", trap_valid, 0);
        for (int n = 0; n < 2600; n++) begin
            if (n != 0) @(negedge clk);
            // phase 1: completions held so the buffer fills (R1);
            // phase 2: wide register use; phase 3: tight reuse with frequent traps (R8, R9)
            if (n < 40)        drive(1, 8, 64);
            else if (n < 1300) drive(0, 8, 40);
            else               drive(0, 3, 8);
            #1;
            predict();
            compare();
            step();
            cyc++;
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule